// File: doc/BRIEF.md
# Linear CCD Readout Timing Controller

This block drives the timing of a 2048-pixel linear image sensor from a fast system clock. It produces the sensor's pixel clock by dividing the system clock with a programmable half-period. Once per line it produces a readout-gate pulse. Two programmable guard intervals surround the gate: one between the last pixel clock and the gate, one between the gate and the first pixel clock of the new line. The pixel clock stays low while the gate is high.

Each pixel clock pulse of a line opens an output slot. The block tells downstream logic three things about every slot: its index, whether it carries a real pixel, and whether it is an optical-black reference, a dummy or an effective pixel. The slot map depends on a mode input. With the internal sample-hold in use, there is one extra leading dummy slot. An ADC strobe is raised at a programmable offset after each pixel clock rise. Data-valid and the strobe stay off until the sensor has received a warm-up number of pixel clock pulses.

All configuration is captured once per line, in the cycle before the readout gate rises. Changing it while a line runs therefore only affects later lines.

Top module: `lccd_timing`

## Requirements
- R1: While a line runs, the pixel clock is high for exactly H system cycles and low for exactly H cycles, where H = max(cfg_half, 1).
- R2: The readout gate is high for exactly max(cfg_gate, 1) system cycles, and the pixel clock is low throughout.
- R3: After the gate falls, the pixel clock stays low for exactly max(cfg_post, 1) cycles before its first rise. From the last falling edge of a line's pixel clock to the next gate rise there are exactly H + max(cfg_pre, 1) cycles.
- R4: Each line issues exactly max(cfg_line_clks, N_LEAD+N_EFF+N_TRAIL+2) pixel clock pulses, which is at least 2088 with the default parameters.
- R5: Slot types are coded 2'b00 dummy, 2'b01 optical black and 2'b10 effective. Let d = slot index + 1 without sample-hold (cfg_sh=0), and d = slot index with sample-hold (cfg_sh=1). The slot is black for 13 <= d <= 30, effective for 33 <= d <= 32+N_EFF, and dummy otherwise.
- R6: Pulse k of a line (counting from 0) opens slot k with slot_valid high for k < N_LEAD+cfg_sh+N_EFF+N_TRAIL. Later pulses have slot_valid low, index 0 and type dummy. The slot outputs change in the same cycle as the pixel clock rise.
- R7: For each valid slot of a valid line, adc_strobe is high for one cycle, cfg_strobe_off cycles after the pixel clock rise. There is no strobe when the offset is 2H or more.
- R8: line_start is high for one cycle with the rise of pulse 0. line_end is high for one cycle with the rise of the last valid slot.
- R9: A line is valid only if at least WARMUP pixel clock pulses have been issued since reset before its gate rises. data_valid equals slot_valid on valid lines and stays low on all other lines.
- R10: Configuration is sampled only when a gate starts. A change made during a line does not alter that line.
- R11: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | DIV_W | Pixel clock half-period in system cycles |
| cfg_gate | input | GUARD_W | Readout-gate width in system cycles |
| cfg_pre | input | GUARD_W | Guard after the last low phase before the gate |
| cfg_post | input | GUARD_W | Guard from gate fall to first pixel clock |
| cfg_line_clks | input | LINE_W | Pixel clock pulses per line (integration period) |
| cfg_strobe_off | input | DIV_W+1 | ADC strobe offset after the pixel clock rise |
| cfg_sh | input | 1 | 1 selects the sample-hold slot map |
| pclk_o | output | 1 | Sensor pixel clock |
| rog_o | output | 1 | Readout-gate pulse |
| slot_idx_o | output | IDX_W | Current slot index |
| slot_type_o | output | 2 | Slot type code |
| slot_valid_o | output | 1 | Pulse carries an output slot |
| data_valid_o | output | 1 | Slot valid on a line past warm-up |
| adc_strobe_o | output | 1 | One-cycle ADC sample strobe |
| line_start_o | output | 1 | First slot of a line |
| line_end_o | output | 1 | Last valid slot of a line |

## Verification
Two events can meet in a single cycle: the warm-up threshold being reached, and the configuration being sampled for the next line. The bench sets WARMUP equal to the first line's pulse count, so the count reaches the threshold on that line's final pulse, just before the next gate captures the warm flag. The second line must then be fully valid and the first line fully invalid.

A second coincidence is a configuration write during a running line. New settings are written in the middle of a line. The scoreboard checks that this line keeps its old widths, guards, pulse count and slot map, and that the next line picks up the new ones.

// File: rtl/lccd_pkg.sv
package lccd_pkg;
   typedef enum logic [1:0] {
      SLOT_DUMMY = 2'd0,
      SLOT_DARK  = 2'd1,
      SLOT_EFF   = 2'd2
   } slot_t;

   typedef enum logic [1:0] {
      ST_PRE,
      ST_GATE,
      ST_POST,
      ST_RUN
   } seq_st_t;
endpackage

// File: rtl/lccd_clkdiv.sv
module lccd_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             pclk_c,
   output logic             rise,
   output logic             wrap,
   output logic [DIV_W:0]   ph
);
   logic [DIV_W:0] per_m1;

   assign per_m1 = {half, 1'b0} - (DIV_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)             ph <= '0;
      else if (!run)          ph <= '0;
      else if (ph == per_m1)  ph <= '0;
      else                    ph <= ph + (DIV_W+1)'(1);
   end

   assign pclk_c = run && (ph < {1'b0, half});
   assign rise   = run && (ph == '0);
   assign wrap   = run && (ph == per_m1);

   // R1
   ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ph <= per_m1));
endmodule

// File: rtl/lccd_seq.sv
module lccd_seq
   import lccd_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int GUARD_W = 12,
   parameter int LINE_W  = 16,
   parameter int N_LEAD  = 32,
   parameter int N_EFF   = 2048,
   parameter int N_TRAIL = 6,
   parameter int WARMUP  = 22500
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   cfg_half,
   input  logic [GUARD_W-1:0] cfg_gate,
   input  logic [GUARD_W-1:0] cfg_pre,
   input  logic [GUARD_W-1:0] cfg_post,
   input  logic [LINE_W-1:0]  cfg_line_clks,
   input  logic [DIV_W:0]     cfg_strobe_off,
   input  logic               cfg_sh,
   input  logic               rise,
   input  logic               wrap,
   output logic               run,
   output logic               gate,
   output logic [LINE_W-1:0]  k,
   output logic [DIV_W-1:0]   half_l,
   output logic [DIV_W:0]     strb_l,
   output logic               sh_l,
   output logic               line_ok
);
   localparam int LINE_MIN = N_LEAD + N_EFF + N_TRAIL + 2;
   localparam logic [LINE_W-1:0]  LMIN = LINE_W'(LINE_MIN);
   localparam logic [GUARD_W-1:0] G1   = GUARD_W'(1);

   seq_st_t              st;
   logic [GUARD_W-1:0]   c, gate_l, post_l, pre_l;
   logic [LINE_W-1:0]    plen_l;
   logic                 warm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_PRE;
         c       <= '0;
         gate_l  <= G1;
         post_l  <= G1;
         pre_l   <= G1;
         half_l  <= DIV_W'(1);
         plen_l  <= LMIN;
         strb_l  <= '0;
         sh_l    <= 1'b0;
         k       <= '0;
         line_ok <= 1'b0;
      end else begin
         case (st)
            ST_PRE: begin
               if (c == pre_l - G1) begin
                  gate_l  <= (cfg_gate == '0) ? G1 : cfg_gate;
                  post_l  <= (cfg_post == '0) ? G1 : cfg_post;
                  pre_l   <= (cfg_pre  == '0) ? G1 : cfg_pre;
                  half_l  <= (cfg_half == '0) ? DIV_W'(1) : cfg_half;
                  plen_l  <= (cfg_line_clks < LMIN) ? LMIN : cfg_line_clks;
                  strb_l  <= cfg_strobe_off;
                  sh_l    <= cfg_sh;
                  line_ok <= warm;
                  st      <= ST_GATE;
                  c       <= '0;
               end else begin
                  c <= c + G1;
               end
            end
            ST_GATE: begin
               if (c == gate_l - G1) begin
                  st <= ST_POST;
                  c  <= '0;
               end else begin
                  c <= c + G1;
               end
            end
            ST_POST: begin
               if (c == post_l - G1) begin
                  st <= ST_RUN;
                  c  <= '0;
                  k  <= '0;
               end else begin
                  c <= c + G1;
               end
            end
            default: begin
               if (wrap) begin
                  if (k == plen_l - LINE_W'(1)) begin
                     st <= ST_PRE;
                     c  <= '0;
                  end else begin
                     k <= k + LINE_W'(1);
                  end
               end
            end
         endcase
      end
   end

   generate
      if (WARMUP > 0) begin : g_warm
         localparam int WW = (WARMUP > 1) ? $clog2(WARMUP + 1) : 1;
         localparam logic [WW-1:0] WLIM = WW'(WARMUP);
         logic [WW-1:0] wc;
         always_ff @(posedge clk) begin
            if (!rst_n)                   wc <= '0;
            else if (rise && wc != WLIM)  wc <= wc + WW'(1);
         end
         assign warm = (wc == WLIM);
      end else begin : g_nowarm
         assign warm = 1'b1;
      end
   endgenerate

   assign run  = (st == ST_RUN);
   assign gate = (st == ST_GATE);

   // R4
   pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (k < plen_l));
   // R2
   gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> (c < gate_l));
endmodule

// File: rtl/lccd_slotmap.sv
module lccd_slotmap
   import lccd_pkg::*;
#(
   parameter int LINE_W      = 16,
   parameter int N_LEAD      = 32,
   parameter int N_EFF       = 2048,
   parameter int N_TRAIL     = 6,
   parameter int BLACK_FIRST = 13,
   parameter int N_BLACK     = 18
) (
   input  logic              run,
   input  logic              sh,
   input  logic [LINE_W-1:0] k,
   output logic              valid,
   output logic              last,
   output slot_t             typ
);
   localparam logic [LINE_W-1:0] LEN0  = LINE_W'(N_LEAD + N_EFF + N_TRAIL);
   localparam logic [LINE_W-1:0] DK_LO = LINE_W'(BLACK_FIRST);
   localparam logic [LINE_W-1:0] DK_HI = LINE_W'(BLACK_FIRST + N_BLACK - 1);
   localparam logic [LINE_W-1:0] EF_LO = LINE_W'(N_LEAD + 1);
   localparam logic [LINE_W-1:0] EF_HI = LINE_W'(N_LEAD + N_EFF);

   logic [LINE_W-1:0] len, d;

   assign len   = LEN0 + {{(LINE_W-1){1'b0}}, sh};
   assign d     = k + {{(LINE_W-1){1'b0}}, ~sh};
   assign valid = run && (k < len);
   assign last  = run && (k == len - LINE_W'(1));

   always_comb begin
      if (!valid)                        typ = SLOT_DUMMY;
      else if (d >= DK_LO && d <= DK_HI) typ = SLOT_DARK;
      else if (d >= EF_LO && d <= EF_HI) typ = SLOT_EFF;
      else                               typ = SLOT_DUMMY;
   end
endmodule

// File: rtl/lccd_timing.sv
module lccd_timing
   import lccd_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int GUARD_W     = 12,
   parameter int LINE_W      = 16,
   parameter int IDX_W       = 12,
   parameter int N_LEAD      = 32,
   parameter int N_EFF       = 2048,
   parameter int N_TRAIL     = 6,
   parameter int BLACK_FIRST = 13,
   parameter int N_BLACK     = 18,
   parameter int WARMUP      = 22500
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   cfg_half,
   input  logic [GUARD_W-1:0] cfg_gate,
   input  logic [GUARD_W-1:0] cfg_pre,
   input  logic [GUARD_W-1:0] cfg_post,
   input  logic [LINE_W-1:0]  cfg_line_clks,
   input  logic [DIV_W:0]     cfg_strobe_off,
   input  logic               cfg_sh,
   output logic               pclk_o,
   output logic               rog_o,
   output logic [IDX_W-1:0]   slot_idx_o,
   output logic [1:0]         slot_type_o,
   output logic               slot_valid_o,
   output logic               data_valid_o,
   output logic               adc_strobe_o,
   output logic               line_start_o,
   output logic               line_end_o
);
   localparam int MAX_SLOTS = N_LEAD + 1 + N_EFF + N_TRAIL;
   localparam int LINE_MIN  = N_LEAD + N_EFF + N_TRAIL + 2;

   generate
      if (BLACK_FIRST < 1 || BLACK_FIRST + N_BLACK - 1 > N_LEAD) begin : g_bad_black
         $error("black slots must lie inside the leading dummies");
      end
      if ((2 ** IDX_W) < MAX_SLOTS) begin : g_bad_idx
         $error("IDX_W too narrow for the slot count");
      end
      if ((2 ** LINE_W) <= LINE_MIN) begin : g_bad_line
         $error("LINE_W too narrow for the minimum line");
      end
      if (DIV_W < 1 || GUARD_W < 1) begin : g_bad_div
         $error("divider and guard widths must be positive");
      end
   endgenerate

   logic               run, gate, rise, wrap, pclk_c, sh_l, line_ok;
   logic               sv, last;
   slot_t              typ;
   logic [DIV_W:0]     ph, strb_l;
   logic [DIV_W-1:0]   half_l;
   logic [LINE_W-1:0]  k;

   lccd_seq #(
      .DIV_W(DIV_W), .GUARD_W(GUARD_W), .LINE_W(LINE_W),
      .N_LEAD(N_LEAD), .N_EFF(N_EFF), .N_TRAIL(N_TRAIL), .WARMUP(WARMUP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_half(cfg_half), .cfg_gate(cfg_gate), .cfg_pre(cfg_pre),
      .cfg_post(cfg_post), .cfg_line_clks(cfg_line_clks),
      .cfg_strobe_off(cfg_strobe_off), .cfg_sh(cfg_sh),
      .rise(rise), .wrap(wrap),
      .run(run), .gate(gate), .k(k), .half_l(half_l), .strb_l(strb_l),
      .sh_l(sh_l), .line_ok(line_ok)
   );

   lccd_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .half(half_l),
      .pclk_c(pclk_c), .rise(rise), .wrap(wrap), .ph(ph)
   );

   lccd_slotmap #(
      .LINE_W(LINE_W), .N_LEAD(N_LEAD), .N_EFF(N_EFF), .N_TRAIL(N_TRAIL),
      .BLACK_FIRST(BLACK_FIRST), .N_BLACK(N_BLACK)
   ) u_map (
      .run(run), .sh(sh_l), .k(k), .valid(sv), .last(last), .typ(typ)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pclk_o       <= 1'b0;
         rog_o        <= 1'b0;
         slot_idx_o   <= '0;
         slot_type_o  <= SLOT_DUMMY;
         slot_valid_o <= 1'b0;
         data_valid_o <= 1'b0;
         adc_strobe_o <= 1'b0;
         line_start_o <= 1'b0;
         line_end_o   <= 1'b0;
      end else begin
         pclk_o       <= pclk_c;
         rog_o        <= gate;
         slot_idx_o   <= sv ? k[IDX_W-1:0] : '0;
         slot_type_o  <= typ;
         slot_valid_o <= sv;
         data_valid_o <= sv && line_ok;
         adc_strobe_o <= sv && line_ok && (ph == strb_l);
         line_start_o <= rise && (k == '0);
         line_end_o   <= rise && last;
      end
   end

   // R2
   pclk_quiet_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rog_o |-> !pclk_o);
   // R8
   line_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start_o |-> (slot_valid_o && pclk_o && slot_idx_o == '0));
   // R6
   end_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_end_o |-> (slot_valid_o && $rose(pclk_o)));
   // R9
   dv_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> slot_valid_o);
   // R7
   strobe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_strobe_o |-> data_valid_o);
endmodule

// File: tb/lccd_timing_bench.sv
module lccd_timing_bench;
   localparam int NE   = 16;
   localparam int WARM = 60;
   localparam int LMIN = 32 + NE + 6 + 2;

   typedef struct {
      int h, gate, post, pre, plen, strb, len;
      bit sh, ok;
   } line_t;
   typedef struct {
      int idx, typ;
      bit dv;
   } slot_e;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [7:0]  cfg_half;
   logic [11:0] cfg_gate, cfg_pre, cfg_post;
   logic [15:0] cfg_line_clks;
   logic [8:0]  cfg_strobe_off;
   logic        cfg_sh;
   logic        pclk, rog, sv, dv, strobe, ls, le;
   logic [11:0] idx;
   logic [1:0]  styp;

   lccd_timing #(.N_EFF(NE), .WARMUP(WARM)) u_lccd_timing (
      .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_gate(cfg_gate),
      .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_line_clks(cfg_line_clks),
      .cfg_strobe_off(cfg_strobe_off), .cfg_sh(cfg_sh),
      .pclk_o(pclk), .rog_o(rog), .slot_idx_o(idx), .slot_type_o(styp),
      .slot_valid_o(sv), .data_valid_o(dv), .adc_strobe_o(strobe),
      .line_start_o(ls), .line_end_o(le)
   );

   always #5 clk = ~clk;

   int total = 0, fails = 0;
   bit done = 1'b0;
   line_t lq[$];
   slot_e sq[$];

   task automatic chk_eq(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_type(input int i, input bit sh);
      int d = i + (sh ? 0 : 1);
      if (d >= 13 && d <= 30) return 1;
      if (d >= 33 && d <= 32 + NE) return 2;
      return 0;
   endfunction

   task automatic plan_line(input int h, input int g, input int po, input int pr,
                            input int p, input int st, input bit sh, input bit ok);
      line_t L;
      L.h = (h == 0) ? 1 : h;  L.gate = (g == 0) ? 1 : g;
      L.post = (po == 0) ? 1 : po;  L.pre = (pr == 0) ? 1 : pr;
      L.plen = (p < LMIN) ? LMIN : p;  L.strb = st;
      L.sh = sh;  L.ok = ok;  L.len = 32 + (sh ? 1 : 0) + NE + 6;
      lq.push_back(L);
      for (int i = 0; i < L.len; i++) begin
         slot_e s;
         s.idx = i;  s.typ = exp_type(i, sh);  s.dv = ok;
         sq.push_back(s);
      end
   endtask

   task automatic set_cfg(input int h, input int g, input int po, input int pr,
                          input int p, input int st, input bit sh);
      cfg_half = 8'(h);  cfg_gate = 12'(g);  cfg_post = 12'(po);
      cfg_pre = 12'(pr);  cfg_line_clks = 16'(p);  cfg_strobe_off = 9'(st);
      cfg_sh = sh;
   endtask

   // monitor / scoreboard
   line_t L;
   bit have_cur = 0, wait_first = 0, prev_pclk = 0, prev_rog = 0;
   int since_rise = 0, since_fall = 0, since_rfall = 0, rog_w = 0;
   int pulses = 0, strobes = 0, ls_n = 0, le_n = 0, lines = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         since_rise++;  since_fall++;  since_rfall++;
         if (rog && !prev_rog) begin
            if (have_cur) begin
               chk_eq("R4/R10 pulses per line", pulses, L.plen);
               chk_eq("R3 pre-gate low gap", since_fall, L.h + L.pre);
               chk_eq("R7 strobes per line", strobes,
                      (L.ok && L.strb < 2 * L.h) ? L.len : 0);
               chk_eq("R8 line_start count", ls_n, 1);
               chk_eq("R8 line_end count", le_n, 1);
            end
            if (lq.size() == 0) begin
               chk_eq("R4 unplanned line", 1, 0);
               done = 1;
            end else begin
               L = lq.pop_front();
            end
            have_cur = 1;  pulses = 0;  strobes = 0;  ls_n = 0;  le_n = 0;
            rog_w = 0;  lines++;
            if (lines == 5) done = 1;
         end
         if (rog) begin
            rog_w++;
            if (pclk) chk_eq("R2 pclk low during gate", pclk, 0);
         end
         if (!rog && prev_rog) begin
            chk_eq("R2 gate width", rog_w, L.gate);
            since_rfall = 0;  wait_first = 1;
         end
         if (pclk && !prev_pclk) begin
            if (wait_first) chk_eq("R3 post-gate guard", since_rfall, L.post);
            else            chk_eq("R1 pclk period", since_rise, 2 * L.h);
            wait_first = 0;
            if (pulses < L.len) begin
               slot_e s;
               if (sq.size() == 0) begin
                  chk_eq("R6 slot queue empty", 1, 0);
               end else begin
                  s = sq.pop_front();
                  chk_eq("R6 slot valid", sv, 1);
                  chk_eq("R6 slot index", idx, s.idx);
                  chk_eq("R5 slot type", styp, s.typ);
                  chk_eq("R9 data valid", dv, s.dv);
               end
            end else begin
               chk_eq("R6 no slot past line", sv, 0);
               chk_eq("R9 no data past line", dv, 0);
            end
            chk_eq("R8 line_start position", ls, (pulses == 0) ? 1 : 0);
            chk_eq("R8 line_end position", le, (pulses == L.len - 1) ? 1 : 0);
            pulses++;
            since_rise = 0;
         end
         if (!pclk && prev_pclk) begin
            chk_eq("R1 pclk high width", since_rise, L.h);
            since_fall = 0;
         end
         if (strobe) begin
            chk_eq("R7 strobe offset", since_rise, L.strb);
            strobes++;
         end
         if (ls) ls_n++;
         if (le) le_n++;
         prev_pclk = pclk;  prev_rog = rog;
      end
   end

   task automatic summary;
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      set_cfg(2, 5, 3, 2, 60, 1, 1'b0);
      repeat (3) @(negedge clk);
      chk_eq("R11 outputs in reset",
             int'({pclk, rog, sv, dv, strobe, ls, le, styp, idx}), 0);
      plan_line(2, 5, 3, 2, 60, 1, 1'b0, 1'b0);  // warm-up not reached
      plan_line(2, 5, 3, 2, 60, 1, 1'b0, 1'b1);  // exactly WARM pulses before
      rst_n = 1'b1;
      @(posedge ls);
      @(posedge ls);
      @(negedge clk);
      // R10: new settings mid-line, applied from the next gate
      set_cfg(3, 1, 1, 1, 10, 5, 1'b1);
      plan_line(3, 1, 1, 1, 10, 5, 1'b1, 1'b1);
      @(posedge ls);
      @(negedge clk);
      set_cfg(1, 0, 0, 0, 70, 2, 1'b0);
      plan_line(1, 0, 0, 0, 70, 2, 1'b0, 1'b1);
      plan_line(1, 0, 0, 0, 70, 2, 1'b0, 1'b1);
      wait (done);
      @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;  fails++;
         $display("FAIL watchdog: run hung actual=0 expected=1");
         summary();
         $finish;
      end
   end
endmodule